// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block produces the external memory bus timing for an 8-bit controller core. The low address and data share one port, and a second port carries the high address byte. The core hands over one request at a time. A request is either a program fetch, built from the program counter, or a data transfer. A data transfer comes with a low address byte, a direction, and a flag that selects the high-address source: the data pointer high byte or the stored port-2 register. From each request the block generates the address latch enable, the program-store strobe, and the read and write strobes. It also drives the two ports and returns the byte captured from the bus.

A fetch occupies six oscillator periods and a data transfer occupies twelve. The next request is accepted in the final period of the current one, so bus cycles can follow each other with no gap. Two consecutive fetches therefore fit into one twelve-period machine cycle and give two program-store pulses. A data transfer takes the place of that fetch pair. A fetch goes onto the bus only when the external-only input is set or the program counter lies above a threshold. Any other fetch still takes six periods but leaves all strobes quiet. All strobes are active low, and the block also provides their AND as one read strobe for a memory shared between program and data.

Top module: `ebus_sequencer`

## Requirements
- R1: A fetch accepted at a clock edge raises `done_o` in the sixth period after that edge (period index 5, counting the first period after acceptance as 0).
- R2: A data transfer (`req_kind_i`=1) raises `done_o` in period index 11, and during the transfer `ale_o` is high for exactly one period (index 0).
- R3: A fetch is external when `ext_only_i`=1 or `pc_i` > 16'h3FFF. An internal fetch keeps `ale_o` low and all strobes high for its whole duration.
- R4: An external fetch holds `psen_n_o` low for two periods (indices 3 and 4). A read holds `rd_n_o` low for six periods (indices 4 to 9), and a write holds `wr_n_o` low for the same six periods. At most one of the three strobes is low at any time.
- R5: While a bus cycle is active, `p2_o` carries `pc_i[15:8]` for a fetch. For a data transfer it carries `dph_i` when `req_ptr_i`=1 and `p2_reg_i` when `req_ptr_i`=0. All of these values are captured at acceptance.
- R6: When no external cycle is active, `p2_o` equals the live `p2_reg_i`.
- R7: The low address (`pc_i[7:0]` for a fetch, `xlo_i` for data) is driven on `p0_out_o` with `p0_oe_o`=1 during the ALE period, and it stays driven and unchanged for at least the period after ALE falls.
- R8: On any read, `p0_oe_o` is 0 in the period before the read strobe falls and for as long as the strobe is low. `rdata_o` holds the `p0_in_i` value sampled at the end of the last strobe-low period.
- R9: On a write, `wdata_i` is driven with `p0_oe_o`=1 from index 3 to index 10, which is one period before `wr_n_o` falls until one period after it rises.
- R10: `mem_rd_n_o` is low exactly when `psen_n_o` or `rd_n_o` is low.
- R11: `req_ready_o` is high when idle and in the last period of a cycle. A request held valid is therefore accepted back to back, and consecutive ALE pulses are 6 periods apart for fetches and 12 for data transfers.
- R12: In reset, `ale_o`=0, all strobes are 1, `p0_oe_o`=0, `done_o`=0 and `req_ready_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one state per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_kind_i | input | 1 | 0 = program fetch, 1 = data transfer |
| req_wr_i | input | 1 | Data direction, 1 = write |
| req_ptr_i | input | 1 | High-address source for data: 1 = pointer high byte, 0 = port-2 register |
| ext_only_i | input | 1 | Forces every fetch onto the external bus |
| pc_i | input | 16 | Program counter for fetches |
| xlo_i | input | 8 | Low address byte for data transfers |
| dph_i | input | 8 | Data pointer high byte |
| p2_reg_i | input | 8 | Stored port-2 register value |
| wdata_i | input | 8 | Byte to write |
| req_ready_o | output | 1 | Request is accepted at the next edge if valid |
| done_o | output | 1 | Last period of the current cycle |
| rdata_o | output | 8 | Byte captured by the latest external read |
| ale_o | output | 1 | Address latch enable, active high |
| psen_n_o | output | 1 | Program-store strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| mem_rd_n_o | output | 1 | Combined read strobe for shared memory, active low |
| p0_out_o | output | 8 | Multiplexed address/data out |
| p0_oe_o | output | 1 | Output enable of the multiplexed port |
| p0_in_i | input | 8 | Multiplexed port pins in |
| p2_o | output | 8 | High-address port |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, 8-bit data, and an internal program limit of 16'h3FFF. With these values the fetch sweep can cover both sides of the threshold, the two ends of the address space, and both settings of the external-only input. The data sweep covers every combination of direction and high-address source over several address and port-register values. A small memory model answers reads with a byte derived from the latched address and the high port, so a wrong source or a late sample shows up in `rdata_o`. Back-to-back runs of each cycle type measure the ALE spacing directly.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  typedef enum logic {K_FETCH = 1'b0, K_DATA = 1'b1} acc_kind_e;

  localparam int FETCH_LEN = 6;
  localparam int DATA_LEN  = 12;
  localparam int CNT_W     = $clog2(DATA_LEN);

  typedef logic [CNT_W-1:0] cnt_t;

  // fetch phase map
  localparam cnt_t F_LAST      = cnt_t'(FETCH_LEN - 1);
  localparam cnt_t F_ADDR_END  = cnt_t'(1);
  localparam cnt_t F_STB_FIRST = cnt_t'(3);
  localparam cnt_t F_STB_LAST  = cnt_t'(4);

  // data phase map
  localparam cnt_t D_LAST      = cnt_t'(DATA_LEN - 1);
  localparam cnt_t D_ADDR_END  = cnt_t'(2);
  localparam cnt_t D_WD_FIRST  = cnt_t'(3);
  localparam cnt_t D_STB_FIRST = cnt_t'(4);
  localparam cnt_t D_STB_LAST  = cnt_t'(9);
  localparam cnt_t D_WD_LAST   = cnt_t'(10);

endpackage

// File: rtl/ebus_seq_ctrl.sv
module ebus_seq_ctrl
  import ebus_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter int              DATA_W  = 8,
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h3FFF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  acc_kind_e                req_kind,
  input  logic                     req_wr,
  input  logic                     req_ptr,
  input  logic                     ext_only,
  input  logic [ADDR_W-1:0]        pc,
  input  logic [DATA_W-1:0]        xlo,
  input  logic [ADDR_W-DATA_W-1:0] dph,
  input  logic [ADDR_W-DATA_W-1:0] p2_reg,
  input  logic [DATA_W-1:0]        wdata,
  output logic                     busy,
  output cnt_t                     cnt,
  output acc_kind_e                kind,
  output logic                     wr,
  output logic                     ext,
  output logic [DATA_W-1:0]        lo,
  output logic [ADDR_W-DATA_W-1:0] hi,
  output logic [DATA_W-1:0]        wd,
  output logic                     last,
  output logic                     ready
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic             busy_q, busy_d;
  cnt_t             cnt_q, cnt_d;
  acc_kind_e        kind_q;
  logic             wr_q, ext_q;
  logic [DATA_W-1:0] lo_q, wd_q;
  logic [HI_W-1:0]  hi_q;

  logic             accept;
  logic             ext_d;
  logic [DATA_W-1:0] lo_d;
  logic [HI_W-1:0]  hi_d;

  // next-state logic
  always_comb begin
    last   = busy_q && (cnt_q == ((kind_q == K_DATA) ? D_LAST : F_LAST));
    ready  = !busy_q || last;
    accept = req_valid && ready;

    ext_d = (req_kind == K_DATA) || ext_only || (pc > INT_TOP);
    lo_d  = (req_kind == K_DATA) ? xlo : pc[DATA_W-1:0];
    if (req_kind == K_FETCH) hi_d = pc[ADDR_W-1:DATA_W];
    else if (req_ptr)        hi_d = dph;
    else                     hi_d = p2_reg;

    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (last) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + cnt_t'(1);
    end
  end

  // sequencing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // request capture, enabled by acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_FETCH;
      wr_q   <= 1'b0;
      ext_q  <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
      wd_q   <= '0;
    end else if (accept) begin
      kind_q <= req_kind;
      wr_q   <= req_wr && (req_kind == K_DATA);
      ext_q  <= ext_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      wd_q   <= wdata;
    end
  end

  assign busy = busy_q;
  assign cnt  = cnt_q;
  assign kind = kind_q;
  assign wr   = wr_q;
  assign ext  = ext_q;
  assign lo   = lo_q;
  assign hi   = hi_q;
  assign wd   = wd_q;

endmodule

// File: rtl/ebus_strobe_dec.sv
module ebus_strobe_dec
  import ebus_pkg::*;
(
  input  logic      busy,
  input  cnt_t      cnt,
  input  acc_kind_e kind,
  input  logic      wr,
  input  logic      ext,
  output logic      bus_act,
  output logic      ale,
  output logic      psen_n,
  output logic      rd_n,
  output logic      wr_n,
  output logic      addr_ph,
  output logic      wd_ph,
  output logic      cap
);

  logic is_data;
  logic stb;

  always_comb begin
    bus_act = busy && ext;
    is_data = (kind == K_DATA);

    if (is_data) begin
      addr_ph = (cnt <= D_ADDR_END);
      stb     = (cnt >= D_STB_FIRST) && (cnt <= D_STB_LAST);
      wd_ph   = wr && (cnt >= D_WD_FIRST) && (cnt <= D_WD_LAST);
      cap     = !wr && (cnt == D_STB_LAST);
    end else begin
      addr_ph = (cnt <= F_ADDR_END);
      stb     = (cnt >= F_STB_FIRST) && (cnt <= F_STB_LAST);
      wd_ph   = 1'b0;
      cap     = (cnt == F_STB_LAST);
    end

    ale    = bus_act && (cnt == '0);
    psen_n = !(bus_act && !is_data && stb);
    rd_n   = !(bus_act && is_data && !wr && stb);
    wr_n   = !(bus_act && is_data && wr && stb);
    cap    = cap && bus_act;
  end

endmodule

// File: rtl/ebus_port_drv.sv
module ebus_port_drv #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_act,
  input  logic              addr_ph,
  input  logic              wd_ph,
  input  logic              cap,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] wd,
  input  logic [HI_W-1:0]   hi,
  input  logic [HI_W-1:0]   p2_reg,
  input  logic [DATA_W-1:0] p0_in,
  output logic [DATA_W-1:0] p0_out,
  output logic              p0_oe,
  output logic [HI_W-1:0]   p2_out,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    p0_oe  = bus_act && (addr_ph || wd_ph);
    p0_out = addr_ph ? lo : wd;
    p2_out = bus_act ? hi : p2_reg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata_q <= '0;
    else if (cap) rdata_q <= p0_in;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/ebus_sequencer.sv
module ebus_sequencer
  import ebus_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter int              DATA_W  = 8,
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h3FFF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid_i,
  input  logic                     req_kind_i,
  input  logic                     req_wr_i,
  input  logic                     req_ptr_i,
  input  logic                     ext_only_i,
  input  logic [ADDR_W-1:0]        pc_i,
  input  logic [DATA_W-1:0]        xlo_i,
  input  logic [ADDR_W-DATA_W-1:0] dph_i,
  input  logic [ADDR_W-DATA_W-1:0] p2_reg_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic                     req_ready_o,
  output logic                     done_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     ale_o,
  output logic                     psen_n_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic                     mem_rd_n_o,
  output logic [DATA_W-1:0]        p0_out_o,
  output logic                     p0_oe_o,
  input  logic [DATA_W-1:0]        p0_in_i,
  output logic [ADDR_W-DATA_W-1:0] p2_o
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic              busy, wr, ext, last, ready;
  cnt_t              cnt;
  acc_kind_e         kind;
  logic [DATA_W-1:0] lo, wd;
  logic [HI_W-1:0]   hi;
  logic              bus_act, addr_ph, wd_ph, cap;

  ebus_seq_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .INT_TOP(INT_TOP)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid_i),
    .req_kind (acc_kind_e'(req_kind_i)),
    .req_wr   (req_wr_i),
    .req_ptr  (req_ptr_i),
    .ext_only (ext_only_i),
    .pc       (pc_i),
    .xlo      (xlo_i),
    .dph      (dph_i),
    .p2_reg   (p2_reg_i),
    .wdata    (wdata_i),
    .busy     (busy),
    .cnt      (cnt),
    .kind     (kind),
    .wr       (wr),
    .ext      (ext),
    .lo       (lo),
    .hi       (hi),
    .wd       (wd),
    .last     (last),
    .ready    (ready)
  );

  ebus_strobe_dec u_dec (
    .busy   (busy),
    .cnt    (cnt),
    .kind   (kind),
    .wr     (wr),
    .ext    (ext),
    .bus_act(bus_act),
    .ale    (ale_o),
    .psen_n (psen_n_o),
    .rd_n   (rd_n_o),
    .wr_n   (wr_n_o),
    .addr_ph(addr_ph),
    .wd_ph  (wd_ph),
    .cap    (cap)
  );

  ebus_port_drv #(
    .DATA_W(DATA_W),
    .HI_W  (HI_W)
  ) u_port (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_act(bus_act),
    .addr_ph(addr_ph),
    .wd_ph  (wd_ph),
    .cap    (cap),
    .lo     (lo),
    .wd     (wd),
    .hi     (hi),
    .p2_reg (p2_reg_i),
    .p0_in  (p0_in_i),
    .p0_out (p0_out_o),
    .p0_oe  (p0_oe_o),
    .p2_out (p2_o),
    .rdata  (rdata_o)
  );

  assign mem_rd_n_o  = psen_n_o & rd_n_o;
  assign done_o      = last;
  assign req_ready_o = ready;

endmodule

// File: rtl/ebus_sequencer_chk.sv
module ebus_sequencer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ale,
  input logic              psen_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              p0_oe,
  input logic [DATA_W-1:0] p0_out
);

  logic       ale_q;
  logic       seen_q;
  logic [7:0] gap_q;
  logic       ale_rise;

  assign ale_rise = ale && !ale_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q  <= 1'b0;
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      ale_q <= ale;
      if (ale_rise) begin
        seen_q <= 1'b1;
        gap_q  <= 8'd1;
      end else if (gap_q != 8'hFF) begin
        gap_q  <= gap_q + 8'd1;
      end
    end
  end

  // R11: successive ALE pulses never closer than a fetch cycle
  a_r11_ale_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_rise && seen_q) |-> (gap_q >= 8'd6));

  // R4: strobes never overlap
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

  // R8: port released while a read strobe is low
  a_r8_float_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n) |-> !p0_oe);

  // R7: address still driven and steady as ALE falls
  a_r7_addr_at_ale_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (p0_oe && $stable(p0_out)));

  // R9: write data set up before the strobe falls
  a_r9_data_before_wr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> ($past(p0_oe) && $stable(p0_out)));

  // R9: write data held after the strobe rises
  a_r9_data_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (p0_oe && $stable(p0_out)));

endmodule

bind ebus_sequencer ebus_sequencer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ale   (ale_o),
  .psen_n(psen_n_o),
  .rd_n  (rd_n_o),
  .wr_n  (wr_n_o),
  .p0_oe (p0_oe_o),
  .p0_out(p0_out_o)
);

// File: tb/ebus_sequencer_tb.sv
module ebus_sequencer_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_kind, req_wr, req_ptr, ext_only;
  logic [15:0] pc;
  logic [7:0]  xlo, dph, p2_reg, wdata;
  logic        req_ready, done, ale, psen_n, rd_n, wr_n, mem_rd_n, p0_oe;
  logic [7:0]  rdata, p0_out, p0_in, p2;
  logic [7:0]  lat_lo;

  int nchk  = 0;
  int nfail = 0;
  bit finished = 0;

  ebus_sequencer u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid_i(req_valid),
    .req_kind_i (req_kind),
    .req_wr_i   (req_wr),
    .req_ptr_i  (req_ptr),
    .ext_only_i (ext_only),
    .pc_i       (pc),
    .xlo_i      (xlo),
    .dph_i      (dph),
    .p2_reg_i   (p2_reg),
    .wdata_i    (wdata),
    .req_ready_o(req_ready),
    .done_o     (done),
    .rdata_o    (rdata),
    .ale_o      (ale),
    .psen_n_o   (psen_n),
    .rd_n_o     (rd_n),
    .wr_n_o     (wr_n),
    .mem_rd_n_o (mem_rd_n),
    .p0_out_o   (p0_out),
    .p0_oe_o    (p0_oe),
    .p0_in_i    (p0_in),
    .p2_o       (p2)
  );

  // memory model: byte depends on latched low address and high port
  assign p0_in = lat_lo ^ p2 ^ 8'h5A;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_one(input bit kind, input bit wr, input bit ptr, input bit ea,
                         input logic [15:0] a_pc, input logic [7:0] a_lo,
                         input logic [7:0] a_dph, input logic [7:0] a_p2,
                         input logic [7:0] a_wd);
    int len;
    bit ext;
    logic [7:0] hi_exp, lo_exp, lat;
    int nale, npsen, nrd, nwr, nmem, done_at, hi_bad, wd_bad, oe_bad, strobe_seen;
    len    = kind ? 12 : 6;
    ext    = kind || ea || (a_pc > 16'h3FFF);
    hi_exp = !kind ? a_pc[15:8] : (ptr ? a_dph : a_p2);
    lo_exp = kind ? a_lo : a_pc[7:0];
    nale = 0; npsen = 0; nrd = 0; nwr = 0; nmem = 0; done_at = -1;
    hi_bad = 0; wd_bad = 0; oe_bad = 0; strobe_seen = 0; lat = 8'h00;

    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_wr = wr; req_ptr = ptr;
    ext_only = ea; pc = a_pc; xlo = a_lo; dph = a_dph; p2_reg = a_p2; wdata = a_wd;
    chk(req_ready == 1'b1, "R11 ready when idle", int'(req_ready), 1);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) begin
        req_valid = 1'b0;
        lat = p0_out;
        lat_lo = p0_out;
      end
      if (ale) nale++;
      if (!psen_n) npsen++;
      if (!rd_n) nrd++;
      if (!wr_n) begin
        nwr++;
        if (!p0_oe || p0_out != a_wd) wd_bad++;
      end
      if (!mem_rd_n) nmem++;
      if ((!psen_n || !rd_n) && p0_oe) oe_bad++;
      if (ext && p2 != hi_exp) hi_bad++;
      if (!ext && p2 != a_p2) hi_bad++;
      if (done && done_at < 0) done_at = i;
      if (ext && kind && wr && i == 3 && (!p0_oe || p0_out != a_wd)) wd_bad++;
      if (ext && kind && wr && i == 10 && (!p0_oe || p0_out != a_wd)) wd_bad++;
      if (ext && !(kind && wr) && i == (kind ? 3 : 2) && p0_oe) oe_bad++;
    end

    if (kind) chk(done_at == 11, "R2 data cycle length", done_at, 11);
    else      chk(done_at == 5,  "R1 fetch cycle length", done_at, 5);
    chk(nale == (ext ? 1 : 0), "R3 ale count", nale, ext ? 1 : 0);
    if (!kind) begin
      chk(npsen == (ext ? 2 : 0), "R4 psen periods", npsen, ext ? 2 : 0);
      chk(nrd + nwr == 0, "R3 no data strobe on fetch", nrd + nwr, 0);
    end else begin
      chk(npsen == 0, "R4 no psen on data", npsen, 0);
      chk(nrd == (wr ? 0 : 6), "R4 rd periods", nrd, wr ? 0 : 6);
      chk(nwr == (wr ? 6 : 0), "R4 wr periods", nwr, wr ? 6 : 0);
    end
    chk(hi_bad == 0, "R5 high port source", hi_bad, 0);
    chk(nmem == npsen + nrd, "R10 combined read strobe", nmem, npsen + nrd);
    if (ext) begin
      chk(lat == lo_exp, "R7 low address at ALE", int'(lat), int'(lo_exp));
      chk(oe_bad == 0, "R8 port released for read", oe_bad, 0);
      if (kind && wr) chk(wd_bad == 0, "R9 write data window", wd_bad, 0);
      if (!(kind && wr))
        chk(rdata == (lo_exp ^ hi_exp ^ 8'h5A), "R8 captured byte",
            int'(rdata), int'(lo_exp ^ hi_exp ^ 8'h5A));
    end
    @(negedge clk);
    p2_reg = a_p2 ^ 8'hFF;
    #1;
    chk(p2 == (a_p2 ^ 8'hFF), "R6 idle high port follows register", int'(p2), int'(a_p2 ^ 8'hFF));
    chk(done == 1'b0 && ale == 1'b0, "R1 idle after cycle", int'({done, ale}), 0);
  endtask

  task automatic run_pair(input bit kind);
    int len, t, first, second, np;
    len = kind ? 12 : 6;
    first = -1; second = -1; np = 0; t = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_wr = 1'b0; req_ptr = 1'b1;
    ext_only = 1'b1; pc = 16'h0100; xlo = 8'h33; dph = 8'h44;
    while (second < 0 && t < 40) begin
      @(negedge clk);
      if (first >= 0 && t - first < 12 && !psen_n) np++;
      if (ale) begin
        if (first < 0) first = t;
        else second = t;
      end
      if (first >= 0 && t - first < 12 && !psen_n && second >= 0) np = np;
      t++;
    end
    req_valid = 1'b0;
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      if (!kind && t - first < 12 && !psen_n) np++;
      t++;
    end
    chk(second - first == len, "R11 back-to-back ALE spacing", second - first, len);
    if (!kind) chk(np == 4, "R4 psen periods over one 12-period machine cycle", np, 4);
    @(negedge clk);
  endtask

  initial begin
    req_valid = 0; req_kind = 0; req_wr = 0; req_ptr = 0; ext_only = 0;
    pc = 16'h0; xlo = 8'h0; dph = 8'h0; p2_reg = 8'hC3; wdata = 8'h0; lat_lo = 8'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(ale == 1'b0, "R12 ale in reset", int'(ale), 0);
    chk({psen_n, rd_n, wr_n, mem_rd_n} == 4'hF, "R12 strobes in reset",
        int'({psen_n, rd_n, wr_n, mem_rd_n}), 15);
    chk(p0_oe == 1'b0 && done == 1'b0, "R12 port and done in reset", int'({p0_oe, done}), 0);
    chk(req_ready == 1'b1, "R12 ready in reset", int'(req_ready), 1);
    chk(p2 == 8'hC3, "R6 high port in reset", int'(p2), 8'hC3);
    rst_n = 1'b1;
    @(negedge clk);

    // fetch sweep around the internal limit, both external-only settings
    for (int ea = 0; ea < 2; ea++) begin
      for (int k = 0; k < 6; k++) begin
        logic [15:0] a;
        case (k)
          0: a = 16'h0000;
          1: a = 16'h1234;
          2: a = 16'h3FFF;
          3: a = 16'h4000;
          4: a = 16'h8A55;
          default: a = 16'hFFFF;
        endcase
        run_one(1'b0, 1'b0, 1'b0, ea[0], a, 8'h00, 8'h77, 8'h9C, 8'h00);
      end
    end

    // data sweep: direction x high source x values
    for (int w = 0; w < 2; w++)
      for (int p = 0; p < 2; p++)
        for (int v = 0; v < 4; v++) begin
          logic [7:0] b;
          b = 8'(v * 8'h47 + 8'h11);
          run_one(1'b1, w[0], p[0], 1'b0, 16'h0000, b, b ^ 8'hF0, ~b, b + 8'h23);
        end

    run_pair(1'b0);
    run_pair(1'b1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule